// File: doc/BRIEF.md
# Cycle-Stealing Buffered I/O Channel Scanner

This block moves words between memory and peripherals for a word-oriented processor without running any program code. A pointer visits eight request slots in a fixed circular order, one slot per clock: three buffered input channels, three buffered output channels, an interrupt line and a real-time clock tick. When the slot under the pointer belongs to an active channel that is raising its request flag, the scanner stops. It holds the main program with a stall output and issues one memory access at that channel's current address. When memory grants the access, the channel's address advances and scanning resumes at the next slot. The interrupt and clock slots never touch memory. A pending request in either slot produces a single-cycle event pulse.

Software activates a channel by giving it a first and a last memory address. The channel moves one word per request. It switches itself off after the word at the last address and pulses its completion flag. Requests from a channel that is not active are ignored. Peripherals and the memory array are outside the block. Memory is seen through a request/grant port with a combinational read path.

Top module: `io_buffer_scanner`

## Requirements
- R1: After a synchronous active-low reset, every output is zero: no stall, no memory request, no acknowledge, no event, no completion pulse, and all channels are inactive.
- R2: Slot order is fixed. Slots 0 to 2 are input channels 0 to 2, slots 3 to 5 are output channels 0 to 2, slot 6 is the interrupt and slot 7 is the clock tick. While nothing is transferred, the pointer advances one slot per clock, so a held request in one slot is seen exactly once every 8 clocks. The interrupt slot is polled one clock before the clock slot.
- R3: When an active channel's request is found, `cpu_stall` and `mem_req` rise on the next clock. They stay high with a stable `mem_addr` until the cycle in which `mem_gnt` is high, and both drop on the clock that follows.
- R4: An input-channel transfer drives `mem_we`=1, with the channel's `in_data` word on `mem_wdata`. The channel's `in_ack` bit pulses for one cycle, on the clock after the grant.
- R5: An output-channel transfer drives `mem_we`=0. On the clock after the grant, `out_data` holds the granted `mem_rdata` and that channel's `out_ack` bit pulses for one cycle.
- R6: An `act_valid` pulse with `act_chan` 0 to 5 (input channels 0 to 2, then output channels 0 to 2) loads the first and last addresses and makes the channel active. The first word uses the first address, and each granted word increments the address by one.
- R7: The word at the last address is the channel's final one. Its `chan_done` bit pulses for one cycle together with the acknowledge, and the channel then ignores further requests.
- R8: A request from an inactive channel causes no stall and no memory access.
- R9: An interrupt or clock request found by the pointer produces a one-cycle `irq_evt` or `rtc_evt` pulse on the next clock, with no stall and no memory access.
- R10: After a transfer, scanning continues with the next slot. Two channels that request continuously are therefore served alternately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | Activation strobe |
| act_chan | input | 3 | Channel to activate (0-2 input, 3-5 output) |
| act_start | input | 15 | First memory address |
| act_end | input | 15 | Last memory address |
| in_req | input | 3 | Input channel request flags |
| in_data | input | 144 | Input channel words, channel i at bits i*48 upward |
| in_ack | output | 3 | Input word taken pulses |
| out_req | input | 3 | Output channel request flags |
| out_data | output | 48 | Word read for an output channel |
| out_ack | output | 3 | Output word valid pulses |
| chan_done | output | 6 | Channel completion pulses |
| irq_req | input | 1 | Interrupt request level |
| rtc_req | input | 1 | Clock tick request level |
| irq_evt | output | 1 | Interrupt event pulse |
| rtc_evt | output | 1 | Clock event pulse |
| cpu_stall | output | 1 | Holds the main program |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (input channel) |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 48 | Memory write data |
| mem_rdata | input | 48 | Memory read data |
| mem_gnt | input | 1 | Memory grant, completes access this cycle |

## Verification
The transfer path is driven with one input channel over a three-word block and one output channel over a block ending at the top of the address space. The first shows write data, address stepping and end-of-block shutdown. The second shows read capture and that the address compare is exact at the upper limit. Two channels requesting together show whether scanning resumes after the served slot, which is what makes them alternate. A withheld grant shows that stall and address are held. Held interrupt and clock levels with no channel active show the 8-clock period and the slot order. Requests from all six channels while none is active show that inactive channels are ignored.

// File: rtl/io_scan_pkg.sv
// Shared types for the buffered I/O channel scanner.
package io_scan_pkg;
    // Scanner state: polling slots, or waiting on one memory word.
    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_XFER = 1'b1
    } scan_state_e;
endpackage

// File: rtl/io_chan_addr.sv
// Address keeper for one buffered channel.
// Holds the active flag, the current word address and the last address.
// Assumes step is only raised for a granted word of this channel.
module io_chan_addr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              step,
    output logic              active,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              done
);
    logic [ADDR_W-1:0] last_addr;

    // Load on activation, advance or retire on each granted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cur_addr  <= '0;
            last_addr <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                active    <= 1'b1;
                cur_addr  <= start_addr;
                last_addr <= end_addr;
            end else if (step && active) begin
                if (cur_addr == last_addr) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    cur_addr <= cur_addr + 1'b1;
                end
            end
        end
    end

    a_r7_stop_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step && active && !load && cur_addr == last_addr) |=> (!active && done));
    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && active && !load && cur_addr != last_addr)
            |=> (active && cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/io_scan_ctrl.sv
// Round-robin slot scanner.
// Visits one slot per clock; stops on a channel hit until memory grants,
// then resumes at the following slot. The two slots after the channels
// are event slots that only pulse an event output.
// Assumes hit[] is already qualified with channel activity.
module io_scan_ctrl
    import io_scan_pkg::*;
#(
    parameter int N_CH   = 6,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH+1:0]   hit,
    input  logic              mem_gnt,
    output logic              busy,
    output logic [SLOT_W-1:0] sel,
    output logic              word_done,
    output logic              irq_evt,
    output logic              rtc_evt
);
    localparam int N_SLOT = N_CH + 2;

    scan_state_e       st;
    logic [SLOT_W-1:0] ptr;
    logic [SLOT_W-1:0] ptr_nxt;
    logic              slot_is_ch;

    // Next pointer with wrap after the last slot.
    always_comb begin
        ptr_nxt    = (ptr == SLOT_W'(N_SLOT - 1)) ? '0 : ptr + 1'b1;
        slot_is_ch = (ptr < SLOT_W'(N_CH));
    end

    // Polling and transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_SCAN;
            ptr     <= '0;
            sel     <= '0;
            irq_evt <= 1'b0;
            rtc_evt <= 1'b0;
        end else begin
            irq_evt <= 1'b0;
            rtc_evt <= 1'b0;
            case (st)
                ST_SCAN: begin
                    if (hit[ptr] && slot_is_ch) begin
                        st  <= ST_XFER;
                        sel <= ptr;
                    end else begin
                        irq_evt <= hit[ptr] && (ptr == SLOT_W'(N_CH));
                        rtc_evt <= hit[ptr] && (ptr == SLOT_W'(N_CH + 1));
                        ptr     <= ptr_nxt;
                    end
                end
                default: begin
                    if (mem_gnt) begin
                        st  <= ST_SCAN;
                        ptr <= ptr_nxt;
                    end
                end
            endcase
        end
    end

    // Transfer status towards the datapath.
    always_comb begin
        busy      = (st == ST_XFER);
        word_done = busy && mem_gnt;
    end

    a_r3_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_gnt) |=> (busy && $stable(sel)));
    a_r10_resume_next: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_gnt) |=> (!busy && ptr == $past(ptr_nxt)));
    a_r9_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_evt && rtc_evt));
endmodule

// File: rtl/io_buffer_scanner.sv
// Cycle-stealing buffered I/O scanner, top level.
// Six buffered channels (inputs first, then outputs) plus interrupt and
// clock slots. One word per detected request, with the CPU stalled from
// detection until the memory grant. Memory read data must be valid in the
// grant cycle.
module io_buffer_scanner #(
    parameter  int N_IN   = 3,
    parameter  int N_OUT  = 3,
    parameter  int ADDR_W = 15,
    parameter  int DATA_W = 48,
    localparam int N_CH   = N_IN + N_OUT,
    localparam int N_SLOT = N_CH + 2,
    localparam int SLOT_W = $clog2(N_SLOT),
    localparam int CH_W   = $clog2(N_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act_valid,
    input  logic [CH_W-1:0]        act_chan,
    input  logic [ADDR_W-1:0]      act_start,
    input  logic [ADDR_W-1:0]      act_end,
    input  logic [N_IN-1:0]        in_req,
    input  logic [N_IN*DATA_W-1:0] in_data,
    output logic [N_IN-1:0]        in_ack,
    input  logic [N_OUT-1:0]       out_req,
    output logic [DATA_W-1:0]      out_data,
    output logic [N_OUT-1:0]       out_ack,
    output logic [N_CH-1:0]        chan_done,
    input  logic                   irq_req,
    input  logic                   rtc_req,
    output logic                   irq_evt,
    output logic                   rtc_evt,
    output logic                   cpu_stall,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    input  logic                   mem_gnt
);
    logic [N_CH-1:0]   chan_act;
    logic [ADDR_W-1:0] cur_addr [N_CH];
    logic [N_SLOT-1:0] hit;
    logic              busy;
    logic              word_done;
    logic [SLOT_W-1:0] sel;
    logic              is_input;

    // Slot hit vector: qualified channels, then interrupt, then clock.
    always_comb begin
        hit = {rtc_req, irq_req, ({out_req, in_req} & chan_act)};
    end

    io_scan_ctrl #(.N_CH(N_CH), .SLOT_W(SLOT_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .mem_gnt  (mem_gnt),
        .busy     (busy),
        .sel      (sel),
        .word_done(word_done),
        .irq_evt  (irq_evt),
        .rtc_evt  (rtc_evt)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        io_chan_addr #(.ADDR_W(ADDR_W)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (act_valid && act_chan == CH_W'(g)),
            .start_addr(act_start),
            .end_addr  (act_end),
            .step      (word_done && sel == SLOT_W'(g)),
            .active    (chan_act[g]),
            .cur_addr  (cur_addr[g]),
            .done      (chan_done[g])
        );
    end

    // Memory port driven from the channel being served.
    always_comb begin
        is_input  = (sel < SLOT_W'(N_IN));
        cpu_stall = busy;
        mem_req   = busy;
        mem_we    = busy && is_input;
        mem_addr  = busy ? cur_addr[sel] : '0;
        mem_wdata = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (busy && sel == SLOT_W'(i)) mem_wdata = in_data[i*DATA_W +: DATA_W];
        end
    end

    // Acknowledge pulses and output word capture after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ack   <= '0;
            out_ack  <= '0;
            out_data <= '0;
        end else begin
            in_ack  <= '0;
            out_ack <= '0;
            if (word_done) begin
                if (is_input) begin
                    in_ack[sel] <= 1'b1;
                end else begin
                    out_ack[sel - SLOT_W'(N_IN)] <= 1'b1;
                    out_data <= mem_rdata;
                end
            end
        end
    end

    a_r8_xfer_on_active: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> chan_act[sel]);
    a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_ack, out_ack}));
    a_r5_out_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_ack) |-> $past(mem_gnt && mem_req && !mem_we));
    a_r9_evt_without_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt || rtc_evt) |-> $past(!cpu_stall));
endmodule

// File: tb/io_buffer_scanner_tb_top.sv
module io_buffer_scanner_tb_top;
    localparam int AW = 15;
    localparam int DW = 48;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          act_valid;
    logic [2:0]    act_chan;
    logic [AW-1:0] act_start, act_end;
    logic [2:0]    in_req, in_ack, out_req, out_ack;
    logic [3*DW-1:0] in_data;
    logic [DW-1:0] out_data, mem_wdata, mem_rdata;
    logic [5:0]    chan_done;
    logic          irq_req, rtc_req, irq_evt, rtc_evt;
    logic          cpu_stall, mem_req, mem_we, mem_gnt, gnt_en;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    io_buffer_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_chan(act_chan),
        .act_start(act_start), .act_end(act_end), .in_req(in_req),
        .in_data(in_data), .in_ack(in_ack), .out_req(out_req),
        .out_data(out_data), .out_ack(out_ack), .chan_done(chan_done),
        .irq_req(irq_req), .rtc_req(rtc_req), .irq_evt(irq_evt),
        .rtc_evt(rtc_evt), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
    );

    function automatic logic [DW-1:0] rd_pat(input logic [AW-1:0] a);
        return {a, 33'h1_2345_6789};
    endfunction

    assign mem_gnt   = mem_req & gnt_en;
    assign mem_rdata = rd_pat(mem_addr);

    // Observation logs, filled at the falling edge.
    logic [AW-1:0] lg_addr [64];
    logic          lg_we   [64];
    logic [DW-1:0] lg_wd   [64];
    int            lg_n;
    logic [DW-1:0] od_data [8];
    int            od_ch   [8];
    int            od_n;
    int            irq_t [16];
    int            rtc_t [16];
    int            irq_n, rtc_n, stall_n;
    int            in_ack_n [3];
    int            done_n   [6];

    always @(negedge clk) begin
        cyc++;
        if (mem_req && mem_gnt && lg_n < 64) begin
            lg_addr[lg_n] = mem_addr; lg_we[lg_n] = mem_we; lg_wd[lg_n] = mem_wdata;
            lg_n++;
        end
        if (irq_evt && irq_n < 16) begin irq_t[irq_n] = cyc; irq_n++; end
        if (rtc_evt && rtc_n < 16) begin rtc_t[rtc_n] = cyc; rtc_n++; end
        if (cpu_stall) stall_n++;
        for (int i = 0; i < 3; i++) begin
            if (in_ack[i]) in_ack_n[i]++;
            if (out_ack[i] && od_n < 8) begin od_data[od_n] = out_data; od_ch[od_n] = i; od_n++; end
        end
        for (int i = 0; i < 6; i++) if (chan_done[i]) done_n[i]++;
    end

    task automatic clear_logs();
        lg_n = 0; od_n = 0; irq_n = 0; rtc_n = 0; stall_n = 0;
        for (int i = 0; i < 3; i++) in_ack_n[i] = 0;
        for (int i = 0; i < 6; i++) done_n[i] = 0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic activate(input logic [2:0] ch, input logic [AW-1:0] s, input logic [AW-1:0] e);
        act_valid = 1'b1; act_chan = ch; act_start = s; act_end = e;
        tick(1);
        act_valid = 1'b0;
    endtask

    // R1: outputs quiet under and after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        chk(!cpu_stall && !mem_req, "R1 stall/req in reset", {cpu_stall, mem_req}, 0);
        chk(in_ack == 0 && out_ack == 0, "R1 acks in reset", {in_ack, out_ack}, 0);
        chk(!irq_evt && !rtc_evt && chan_done == 0, "R1 events in reset", {irq_evt, rtc_evt, chan_done}, 0);
        rst_n = 1'b1;
        clear_logs();
        tick(10);
        chk(stall_n == 0 && lg_n == 0, "R1 idle after reset", stall_n, 0);
        chk(out_data == 0, "R1 out_data after reset", out_data, 0);
    endtask

    // R2, R9: event slot period and order, no stall.
    task automatic t_events();
        clear_logs();
        irq_req = 1'b1; rtc_req = 1'b1;
        tick(40);
        irq_req = 1'b0; rtc_req = 1'b0;
        tick(2);
        chk(rtc_n == 5, "R2 clock events in 40 cycles", rtc_n, 5);
        chk(irq_n == 5, "R9 interrupt events in 40 cycles", irq_n, 5);
        chk(rtc_t[1] - rtc_t[0] == 8, "R2 scan period", rtc_t[1] - rtc_t[0], 8);
        chk(((rtc_t[1] - irq_t[1]) % 8 + 8) % 8 == 1, "R2 irq slot before clock slot",
            ((rtc_t[1] - irq_t[1]) % 8 + 8) % 8, 1);
        chk(stall_n == 0 && lg_n == 0, "R9 no stall/memory for events", stall_n + lg_n, 0);
    endtask

    // R8: requests from inactive channels are ignored.
    task automatic t_inactive();
        clear_logs();
        in_req = 3'b111; out_req = 3'b111;
        tick(20);
        in_req = '0; out_req = '0;
        tick(1);
        chk(lg_n == 0, "R8 no memory access", lg_n, 0);
        chk(stall_n == 0, "R8 no stall", stall_n, 0);
    endtask

    // R4, R6, R7: three-word input block.
    task automatic t_input();
        in_data[1*DW +: DW] = 48'hABCD_0000_0001;
        activate(3'd1, 15'h100, 15'h102);
        clear_logs();
        in_req[1] = 1'b1;
        tick(40);
        in_req[1] = 1'b0;
        tick(2);
        chk(lg_n == 3, "R7 words before shutdown", lg_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk(lg_addr[k] == AW'(15'h100 + k), "R6 input address", lg_addr[k], 15'h100 + k);
            chk(lg_we[k] == 1'b1, "R4 write enable", lg_we[k], 1);
            chk(lg_wd[k] == 48'hABCD_0000_0001, "R4 write data", lg_wd[k], 48'hABCD_0000_0001);
        end
        chk(in_ack_n[1] == 3, "R4 in_ack count", in_ack_n[1], 3);
        chk(done_n[1] == 1, "R7 done pulse", done_n[1], 1);
    endtask

    // R5, R6, R7: output block at the top of the address space.
    task automatic t_output();
        activate(3'd4, 15'h7FFE, 15'h7FFF);
        clear_logs();
        out_req[1] = 1'b1;
        tick(30);
        out_req[1] = 1'b0;
        tick(2);
        chk(lg_n == 2, "R7 output words", lg_n, 2);
        chk(lg_we[0] == 1'b0 && lg_we[1] == 1'b0, "R5 read access", {lg_we[0], lg_we[1]}, 0);
        chk(lg_addr[1] == 15'h7FFF, "R6 output address step", lg_addr[1], 15'h7FFF);
        chk(od_n == 2 && od_ch[0] == 1, "R5 out_ack channel", od_ch[0], 1);
        chk(od_data[0] == rd_pat(15'h7FFE), "R5 first out word", od_data[0], rd_pat(15'h7FFE));
        chk(od_data[1] == rd_pat(15'h7FFF), "R5 second out word", od_data[1], rd_pat(15'h7FFF));
        chk(done_n[4] == 1, "R7 output done", done_n[4], 1);
    endtask

    // R3: stall held while the grant is withheld.
    task automatic t_stall();
        int w;
        gnt_en = 1'b0;
        in_data[0 +: DW] = 48'h0000_5555_AAAA;
        activate(3'd0, 15'h040, 15'h040);
        in_req[0] = 1'b1;
        w = 0;
        while (!cpu_stall && w < 12) begin tick(1); w++; end
        chk(w <= 8, "R3 detection latency", w, 8);
        tick(5);
        chk(cpu_stall && mem_req, "R3 stall held", {cpu_stall, mem_req}, 3);
        chk(mem_addr == 15'h040, "R3 address held", mem_addr, 15'h040);
        chk(in_ack == 0, "R3 no ack before grant", in_ack, 0);
        gnt_en = 1'b1;
        tick(1);
        in_req[0] = 1'b0;
        chk(!cpu_stall && !mem_req, "R3 release after grant", {cpu_stall, mem_req}, 0);
        chk(in_ack == 3'b001, "R4 ack after grant", in_ack, 3'b001);
        chk(chan_done[0] == 1'b1, "R7 done with last ack", chan_done, 1);
        tick(1);
        chk(in_ack == 0 && chan_done == 0, "R4 single-cycle pulses", {in_ack, chan_done}, 0);
    endtask

    // R10: two channels requesting together alternate.
    task automatic t_rr();
        logic [AW-1:0] a0, a1;
        in_data[2*DW +: DW] = 48'h2222_0000_2222;
        activate(3'd0, 15'h200, 15'h203);
        activate(3'd2, 15'h300, 15'h303);
        clear_logs();
        in_req[0] = 1'b1; in_req[2] = 1'b1;
        tick(60);
        in_req = '0;
        tick(2);
        chk(lg_n == 8, "R10 total words", lg_n, 8);
        a0 = lg_addr[0];
        a1 = (a0 == 15'h200) ? 15'h300 : 15'h200;
        chk(a0 == 15'h200 || a0 == 15'h300, "R10 first served", a0, 15'h200);
        for (int k = 0; k < 8; k++) begin
            chk(lg_addr[k] == AW'((k % 2 == 0 ? a0 : a1) + k / 2), "R10 alternation",
                lg_addr[k], (k % 2 == 0 ? a0 : a1) + k / 2);
        end
    endtask

    initial begin
        rst_n = 1'b0; act_valid = 1'b0; act_chan = '0; act_start = '0; act_end = '0;
        in_req = '0; out_req = '0; in_data = '0; irq_req = 1'b0; rtc_req = 1'b0;
        gnt_en = 1'b1;
        clear_logs();
        tick(1);
        t_reset();
        t_events();
        t_inactive();
        t_input();
        t_output();
        t_stall();
        t_rr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule